// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Compare Interrupt

This block is a 32-bit down-counting timer peripheral driven through a small word-addressed register port. Software sets a clock source and a prescale divisor, picks whether the counter reloads from a programmed load value or rolls over freely from all-ones, and programs a compare value. When the running count equals the compare value, a sticky flag is raised. That flag produces a level interrupt only while both the compare interrupt and the timer itself are enabled.

The three clock sources reach the block as single-cycle tick-enable inputs in the system clock domain. Source code 00 selects no source and freezes the count. The prescaler passes one count step for every divisor-plus-one selected ticks. A start option loads the counter when the timer is enabled. An overwrite option lets a load-register write replace the running count at once. A self-clearing software reset returns the register state to defaults but keeps the enable and low-power mode bits. The low-power bits are stored and read back only.

Top module: `cmp_timer`

## Requirements
- R1: Word offsets are decoded as 0 control, 1 status, 2 load, 3 compare and 4 counter. Read data is registered and shows the addressed register as it stood before the clock edge. Reads of offsets 5 to 7 return zero, and writes to those offsets change no register.
- R2: A control write stores bits 25:0 only. Bits 31:26 of the control register always read as zero.
- R3: The clock source field in control bits 25:24 selects 00 = none (the counter holds its value), 01 = `ce_per`, 10 = `ce_fast`, 11 = `ce_slow`.
- R4: With prescale field P in control bits 15:4, the counter steps once for every P+1 selected ticks while enabled. The prescale phase restarts from zero whenever the timer is disabled.
- R5: `irq` is 1 exactly one cycle after the status flag, the compare interrupt enable (bit 2) and the timer enable (bit 0) are all 1 together.
- R6: Writing status with bit 0 = 1 clears the compare flag, and this clear takes priority over a match in the same cycle. Writing status with bit 0 = 0 leaves the flag unchanged.
- R7: A control write with bit 16 set keeps only bits 0, 1, 16, 18, 19, 20 and 21 of the written value. The same write clears status, sets load to 0xFFFFFFFF, clears compare and counter, and clears the prescaler phase. Bit 16 clears itself on the next cycle. Hardware reset clears control, status, compare and counter, and sets load to 0xFFFFFFFF.
- R8: On a count step at zero, the counter loads the load register when the reload bit (bit 3) is 1, and wraps to 0xFFFFFFFF when the reload bit is 0.
- R9: A control write that takes enable from 0 to 1 with the start bit (bit 1) set loads the counter with the load value if the written reload bit is 1, and with 0xFFFFFFFF if it is 0. Without the start bit, the counter keeps its value.
- R10: While the overwrite bit (bit 17) is 1, a load-register write also replaces the counter in the same cycle. This takes priority over a count step in that cycle.
- R11: While enabled, the status flag (status bit 0) is set in the cycle after the counter equals the compare value, and it stays set until it is cleared.
- R12: The control bit positions are 0 enable, 1 start, 2 compare interrupt enable, 3 reload, 15:4 prescale, 16 software reset, 17 overwrite, 18 debug, 19 wait, 20 doze, 21 stop, and 25:24 clock source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ce_per | input | 1 | Peripheral clock tick enable |
| ce_fast | input | 1 | High-frequency clock tick enable |
| ce_slow | input | 1 | Slow 32 kHz clock tick enable |
| irq | output | 1 | Level compare interrupt |

## Verification
The hardest state to reach from the ports is the point where several updates to the counter land in the same cycle: a software reset together with an enable rise, an overwrite together with a tick, or a match together with a status clear. Free-running counts near all-ones almost never meet a small compare value. The stimulus therefore keeps load and compare values small and the prescale short, so that matches and reloads happen often. It fires writes, ticks and software resets at random in the same cycles, and a cycle-accurate bench model checks read data and the interrupt on every cycle. Directed sequences come first. They walk the prescale division, the frozen source, both wrap modes, the overwrite, the interrupt gating and the software reset to known counter values.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
package cmp_timer_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_LOAD = 2;
  localparam int OFS_CMP  = 3;
  localparam int OFS_CNT  = 4;

  localparam int B_EN    = 0;
  localparam int B_START = 1;
  localparam int B_CIE   = 2;
  localparam int B_RLD   = 3;
  localparam int B_PS    = 4;
  localparam int B_SWR   = 16;
  localparam int B_OVW   = 17;
  localparam int B_CS    = 24;

  localparam int PS_W = 12;
  localparam int CS_W = 2;

  localparam logic [31:0] CTRL_MASK = 32'h03FF_FFFF;
  localparam logic [31:0] SWR_KEEP  = 32'h003D_0003;

  typedef enum logic [CS_W-1:0] {
    CS_OFF  = 2'b00,
    CS_PER  = 2'b01,
    CS_FAST = 2'b10,
    CS_SLOW = 2'b11
  } clk_src_e;
endpackage

// File: rtl/cmp_timer_regs.sv
`timescale 1ns/1ps
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              hit,
  input  logic [CNT_W-1:0]  cnt,
  output logic              en_o,
  output logic              cie_o,
  output logic              rld_o,
  output logic [CS_W-1:0]   sel_o,
  output logic [PS_W-1:0]   div_o,
  output logic              stat_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              swr_w,
  output logic              start_w,
  output logic [CNT_W-1:0]  start_val,
  output logic              ovw_wr,
  output logic [31:0]       rdata
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [31:0]      ctrl_q;
  logic             stat_q;
  logic [CNT_W-1:0] load_q, cmp_q;
  logic             wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic [31:0]      ctrl_new;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign wr_load = wr_en && (addr == ADDR_W'(OFS_LOAD));
  assign wr_cmp  = wr_en && (addr == ADDR_W'(OFS_CMP));

  always_comb begin
    ctrl_new = wdata & CTRL_MASK;
    if (ctrl_new[B_SWR]) ctrl_new = ctrl_new & SWR_KEEP;
  end

  assign swr_w     = wr_ctrl && wdata[B_SWR];
  assign start_w   = wr_ctrl && wdata[B_EN] && !ctrl_q[B_EN] && wdata[B_START];
  assign start_val = wdata[B_RLD] ? load_q : ALL_ONES;
  assign ovw_wr    = wr_load && ctrl_q[B_OVW];

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_new;
    else              ctrl_q[B_SWR] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || swr_w)             stat_q <= 1'b0;
    else if (wr_stat && wdata[0]) stat_q <= 1'b0;
    else if (hit)                 stat_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || swr_w) begin
      load_q <= ALL_ONES;
      cmp_q  <= '0;
    end else begin
      if (wr_load) load_q <= wdata[CNT_W-1:0];
      if (wr_cmp)  cmp_q  <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        ADDR_W'(OFS_CTRL): rdata <= ctrl_q;
        ADDR_W'(OFS_STAT): rdata <= {31'b0, stat_q};
        ADDR_W'(OFS_LOAD): rdata <= 32'(load_q);
        ADDR_W'(OFS_CMP):  rdata <= 32'(cmp_q);
        ADDR_W'(OFS_CNT):  rdata <= 32'(cnt);
        default:           rdata <= '0;
      endcase
    end
  end

  assign en_o   = ctrl_q[B_EN];
  assign cie_o  = ctrl_q[B_CIE];
  assign rld_o  = ctrl_q[B_RLD];
  assign sel_o  = ctrl_q[B_CS +: CS_W];
  assign div_o  = ctrl_q[B_PS +: PS_W];
  assign stat_o = stat_q;
  assign load_o = load_q;
  assign cmp_o  = cmp_q;

  // R7
  swr_selfclr_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[B_SWR] && !wr_ctrl) |=> !ctrl_q[B_SWR]);

  // R6
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[0]) |=> !stat_q);
endmodule

// File: rtl/cmp_timer_presc.sv
`timescale 1ns/1ps
module cmp_timer_presc
  import cmp_timer_pkg::*;
#(
  parameter int DIV_W = PS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clr,
  input  logic [CS_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic            ce_per,
  input  logic            ce_fast,
  input  logic            ce_slow,
  output logic            tick
);
  logic             src;
  logic [DIV_W-1:0] phase_q;
  logic             last;

  always_comb begin
    case (clk_src_e'(sel))
      CS_PER:  src = ce_per;
      CS_FAST: src = ce_fast;
      CS_SLOW: src = ce_slow;
      default: src = 1'b0;
    endcase
  end

  assign last = (phase_q >= div);
  assign tick = run && src && last;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) phase_q <= '0;
    else if (src)           phase_q <= last ? '0 : phase_q + DIV_W'(1);
  end
endmodule

// File: rtl/cmp_timer_cnt.sv
`timescale 1ns/1ps
module cmp_timer_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             rld,
  input  logic             swr,
  input  logic             start,
  input  logic             ovw_wr,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (swr)    cnt_q <= start ? ALL_ONES : '0;
    else if (start)  cnt_q <= start_val;
    else if (ovw_wr) cnt_q <= wr_val;
    else if (tick) begin
      if (cnt_q == '0) cnt_q <= rld ? load_val : ALL_ONES;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign hit = en && (cnt_q == cmp_val);

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == '0 && !rld && !swr && !start && !ovw_wr) |=> (cnt_q == ALL_ONES));

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !swr && !start && !ovw_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ce_per,
  input  logic              ce_fast,
  input  logic              ce_slow,
  output logic              irq
);
  logic             en, cie, rld, stat, swr, start, ovw_wr, tick, hit;
  logic [CS_W-1:0]  sel;
  logic [PS_W-1:0]  div;
  logic [CNT_W-1:0] load_v, cmp_v, start_val, cnt;

  cmp_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .hit(hit), .cnt(cnt), .en_o(en), .cie_o(cie), .rld_o(rld), .sel_o(sel),
    .div_o(div), .stat_o(stat), .load_o(load_v), .cmp_o(cmp_v), .swr_w(swr),
    .start_w(start), .start_val(start_val), .ovw_wr(ovw_wr), .rdata(bus_rdata)
  );

  cmp_timer_presc #(.DIV_W(PS_W)) u_presc (
    .clk(clk), .rst(rst), .run(en), .clr(swr), .sel(sel), .div(div),
    .ce_per(ce_per), .ce_fast(ce_fast), .ce_slow(ce_slow), .tick(tick)
  );

  cmp_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .rld(rld), .swr(swr),
    .start(start), .ovw_wr(ovw_wr), .start_val(start_val), .load_val(load_v),
    .wr_val(bus_wdata[CNT_W-1:0]), .cmp_val(cmp_v), .cnt_q(cnt), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= stat && cie && en;
  end

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
endmodule

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
  localparam logic [31:0] EN = 32'h1, ST = 32'h2, CIE = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SWR = 32'h1_0000, OVW = 32'h2_0000;
  localparam logic [31:0] SPER = 32'h0100_0000, SFAST = 32'h0200_0000;

  logic clk = 0, rst = 1, bus_we = 0, ce_per = 0, ce_fast = 0, ce_slow = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq;
  int n_vec = 0, n_bad = 0;
  bit chk_on = 0, done = 0;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ce_per(ce_per), .ce_fast(ce_fast), .ce_slow(ce_slow), .irq(irq)
  );

  always #10 clk = ~clk;

  // cycle model built from the requirements
  logic [31:0] m_ctrl, m_ld, m_cmp, m_cnt, m_rd, n_cnt;
  logic        m_st, m_irq, t_en, t_src, t_tk, t_hit, t_swr, t_start, wc, ws, wl, wm;
  logic [11:0] m_pre, t_ps;
  logic [2:0]  m_ra;

  function automatic logic [31:0] rd_model(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return {31'b0, m_st};
      3'd2: return m_ld;
      3'd3: return m_cmp;
      3'd4: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_st = 0; m_ld = '1; m_cmp = 0; m_cnt = 0; m_pre = 0;
      m_irq = 0; m_rd = 0; m_ra = 0;
    end else begin
      t_en = m_ctrl[0];
      t_ps = m_ctrl[15:4];
      case (m_ctrl[25:24])
        2'd1: t_src = ce_per;
        2'd2: t_src = ce_fast;
        2'd3: t_src = ce_slow;
        default: t_src = 0;
      endcase
      t_tk  = t_en && t_src && (m_pre >= t_ps);
      t_hit = t_en && (m_cnt == m_cmp);
      m_rd  = rd_model(bus_addr);
      m_ra  = bus_addr;
      m_irq = m_st && m_ctrl[2] && m_ctrl[0];
      wc = bus_we && bus_addr == 0; ws = bus_we && bus_addr == 1;
      wl = bus_we && bus_addr == 2; wm = bus_we && bus_addr == 3;
      t_swr   = wc && bus_wdata[16];
      t_start = wc && bus_wdata[0] && !m_ctrl[0] && bus_wdata[1];
      if (t_swr)        n_cnt = t_start ? 32'hFFFF_FFFF : 0;
      else if (t_start) n_cnt = bus_wdata[3] ? m_ld : 32'hFFFF_FFFF;
      else if (wl && m_ctrl[17]) n_cnt = bus_wdata;
      else if (t_tk)    n_cnt = (m_cnt == 0) ? (m_ctrl[3] ? m_ld : 32'hFFFF_FFFF) : m_cnt - 1;
      else              n_cnt = m_cnt;
      if (!t_en || t_swr) m_pre = 0;
      else if (t_src)     m_pre = (m_pre >= t_ps) ? 12'd0 : m_pre + 1;
      if (t_swr || (ws && bus_wdata[0])) m_st = 0;
      else if (t_hit) m_st = 1;
      if (t_swr) begin m_ld = '1; m_cmp = 0; end
      else begin
        if (wl) m_ld = bus_wdata;
        if (wm) m_cmp = bus_wdata;
      end
      if (wc) m_ctrl = t_swr ? (bus_wdata & 32'h003D_0003) : (bus_wdata & 32'h03FF_FFFF);
      else    m_ctrl[16] = 0;
      m_cnt = n_cnt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R12";
      3'd1: return "R11";
      3'd2: return "R10";
      3'd4: return "R8";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(tag_of(m_ra), bus_rdata, m_rd);
      chk("R5", {31'b0, irq}, {31'b0, m_irq});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [2:0] m);
    {ce_slow, ce_fast, ce_per} = m;
    @(negedge clk);
    {ce_slow, ce_fast, ce_per} = 3'b000;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    chk_on = 1;
    // reset state
    rd(0, v); chk("R7", v, 32'h0);
    rd(2, v); chk("R7", v, 32'hFFFF_FFFF);
    chk("R5", {31'b0, irq}, 32'h0);
    // R2 and R12: upper control bits dropped, bit 2 kept
    wr(0, 32'hFC00_0004); rd(0, v); chk("R2", v, 32'h4);
    wr(0, 0);
    // R1: unmapped offsets
    wr(5, 32'h1234_5678); wr(7, 32'h0000_00AA);
    rd(5, v); chk("R1", v, 0);
    rd(7, v); chk("R1", v, 0);
    rd(2, v); chk("R1", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R1", v, 0);
    // R4: prescale 2 on peripheral ticks, R9 start from load
    wr(2, 100);
    wr(0, EN | ST | RLD | (32'd2 << 4) | SPER);
    rd(4, v); chk("R9", v, 100);
    repeat (8) pulse(3'b001);
    rd(4, v); chk("R4", v, 98);
    pulse(3'b001);
    rd(4, v); chk("R4", v, 97);
    // R3: source none freezes the count
    wr(0, EN | ST | RLD | (32'd2 << 4));
    repeat (4) pulse(3'b111);
    rd(4, v); chk("R3", v, 97);
    // R3: fast source selected, prescale 0
    wr(0, EN | ST | RLD | SFAST);
    pulse(3'b001); rd(4, v); chk("R3", v, 97);
    pulse(3'b010); rd(4, v); chk("R3", v, 96);
    // R8 reload mode
    wr(0, 0); wr(2, 2);
    wr(0, EN | ST | RLD | SPER);
    rd(4, v); chk("R9", v, 2);
    pulse(3'b001); rd(4, v); chk("R8", v, 1);
    pulse(3'b001); rd(4, v); chk("R8", v, 0);
    pulse(3'b001); rd(4, v); chk("R8", v, 2);
    // R8 free mode, R9 start at all-ones
    wr(0, 0);
    wr(0, EN | ST | SPER);
    rd(4, v); chk("R9", v, 32'hFFFF_FFFF);
    pulse(3'b001); rd(4, v); chk("R8", v, 32'hFFFF_FFFE);
    // R10 overwrite
    wr(0, EN | ST | OVW | SPER);
    wr(2, 1); rd(4, v); chk("R10", v, 1);
    pulse(3'b001); pulse(3'b001);
    rd(4, v); chk("R8", v, 32'hFFFF_FFFF);
    // R11 compare flag and R5 interrupt
    wr(0, 0); wr(1, 1); wr(3, 5); wr(2, 7);
    wr(0, EN | ST | RLD | CIE | SPER);
    rd(1, v); chk("R11", v, 0);
    pulse(3'b001); pulse(3'b001);
    idle(1);
    rd(1, v); chk("R11", v, 1);
    chk("R5", {31'b0, irq}, 1);
    pulse(3'b001);
    wr(0, EN | ST | RLD | SPER);
    idle(1); chk("R5", {31'b0, irq}, 0);
    rd(1, v); chk("R11", v, 1);
    wr(0, EN | ST | RLD | CIE | SPER);
    idle(1); chk("R5", {31'b0, irq}, 1);
    wr(1, 0); rd(1, v); chk("R6", v, 1);
    wr(1, 1); rd(1, v); chk("R6", v, 0);
    chk("R5", {31'b0, irq}, 0);
    // R7 software reset keeps mode bits
    wr(0, EN | ST | RLD | CIE | SWR | OVW | (32'd5 << 4) | 32'h0004_0000 | 32'h0020_0000 | SFAST);
    rd(1, v); chk("R7", v, 0);
    rd(0, v); chk("R7", v, 32'h0024_0003);
    rd(2, v); chk("R7", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R7", v, 0);
    rd(4, v); chk("R7", v, 0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] d;
      logic [2:0]  a;
      a = 3'($urandom % 8);
      d = $urandom;
      case (a)
        3'd0: begin
          d[15:4] = 12'($urandom % 4);
          d[16]   = ($urandom % 24) == 0;
          d[31:26] = 6'($urandom);
        end
        3'd2, 3'd3: d = $urandom % 48;
        default: ;
      endcase
      {ce_slow, ce_fast, ce_per} = 3'($urandom);
      bus_addr = a; bus_wdata = d;
      bus_we = ($urandom % 5) == 0;
      @(negedge clk);
    end
    bus_we = 0;
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule